// File: doc/BRIEF.md
# Raw Pin Mode Entry and Command Controller

This block sits on the host byte stream ahead of the terminal parser. In terminal mode it counts consecutive zero bytes. When twenty zeros in a row have arrived it switches to a raw pin-control mode and answers with a five-byte banner. A shorter run of zeros does not switch it, so a stray NUL from a terminal program cannot trigger the mode. Non-zero bytes in terminal mode go straight through to the terminal path. Zero bytes are held back for counting.

In raw pin mode each incoming byte is a single-byte command. The commands set the direction or the level of seven general pins, repeat the banner, hand the byte stream to an SPI bridge sub-mode, or return to terminal mode. Every pin command is answered with a live read of the pins, taken after the new setting has taken effect. When the SPI bridge reports its exit, the block takes control back, floats every pin and sends the banner again. A reply is offered on a valid/ready output. The block accepts no input byte while a reply is still pending.

Top module: `bbio_ctrl`

## Requirements
- R1: After reset the block is in terminal mode with `spi_active` low and `tx_valid` low. Pins 4..0 are inputs (`pin_oe` bit low) and all levels are 0. Pins 6 and 5 (power, pull-up) are always driven, so after reset `pin_oe` is 7'b1100000 and `pin_out` is 0.
- R2: In terminal mode, twenty consecutive 0x00 bytes switch the block to raw pin mode. The block then replies with the bytes 0x42 0x42 0x49 0x4F 0x31 ("BBIO1"), in that order. Nineteen zeros give no reply.
- R3: In terminal mode a non-zero byte clears the zero count and is presented on `term_valid`/`term_data` in the cycle it is accepted. Zero bytes are never presented there.
- R4: In raw pin mode, 0x00 repeats the five-byte banner.
- R5: In raw pin mode, 0x01 raises `spi_active`. The block itself sends no reply. From then on, input bytes appear on `spi_rx_valid`/`spi_rx_data` and not on the terminal path.
- R6: A `spi_exit` pulse while `spi_active` is high returns the block to raw pin mode. It sets pins 4..0 to inputs, clears all levels and sends the banner.
- R7: In raw pin mode, 0x0F returns the block to terminal mode with no reply and with the pins floated as in R6. A fresh run of twenty zeros is then needed to re-enter.
- R8: A command 010xxxxx sets the directions of pins 4..0 from bits 4..0, where 1 means input (`pin_oe` low) and 0 means output. The block replies {1'b0, pin_in[6:0]} sampled after the change.
- R9: A command 1xxxxxxx sets `pin_out[6:0]` from bits 6..0, with bit 6 power, 5 pull-up, 4 AUX, 3 CS, 2 MISO, 1 CLK and 0 MOSI. The block replies {1'b0, pin_in[6:0]} sampled after the change.
- R10: Any other byte in raw pin mode (001xxxxx, 011xxxxx, and 000xxxxx other than 0x00, 0x01 and 0x0F) replies 0x00 and leaves mode, directions and levels unchanged.
- R11: `rx_ready` is low from the cycle after a reply is started until its last byte has been taken with `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block can take a host byte |
| term_valid | output | 1 | Byte forwarded to the terminal path |
| term_data | output | 8 | Forwarded terminal byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Reply byte taken |
| spi_active | output | 1 | SPI sub-mode owns the byte stream |
| spi_rx_valid | output | 1 | Host byte for the SPI sub-mode |
| spi_rx_data | output | 8 | Host byte for the SPI sub-mode |
| spi_exit | input | 1 | SPI sub-mode requests return |
| pin_in | input | 7 | Live pin levels |
| pin_out | output | 7 | Pin output levels |
| pin_oe | output | 7 | Pin output enables (1 = driven) |

## Verification
Entry detection is tried with zero runs of nineteen and twenty bytes, and with a non-zero byte in the middle of a run. This shows whether the count is exact and whether it clears. Pin commands are driven from a seeded random mix of direction, level and undefined codes. A random external level is applied on every undriven pin, so each reply shows whether it reflects the driven level or the external one and whether the read comes after the update. Directed sequences cover the SPI handoff and return, the reset to terminal mode with re-entry, and the back-pressure on `rx_ready` during a banner.

// File: rtl/bbio_pkg.sv
package bbio_pkg;

    typedef enum logic [1:0] {
        MODE_TERM,
        MODE_RAW,
        MODE_SPI
    } mode_e;

    typedef enum logic [2:0] {
        CMD_BANNER,
        CMD_SPI,
        CMD_RESET,
        CMD_DIR,
        CMD_LEVEL,
        CMD_UNKNOWN
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [6:0] arg;
    } cmd_t;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_BANNER,
        RP_CAPTURE,
        RP_BYTE
    } reply_e;

    localparam int BANNER_LEN = 5;

    // Banner text "BBIO1", one character per index
    function automatic logic [7:0] banner_char(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h42;
            3'd1:    return 8'h42;
            3'd2:    return 8'h49;
            3'd3:    return 8'h4F;
            default: return 8'h31;
        endcase
    endfunction

    // Top bits select pin commands; the rest are exact codes
    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.arg  = b[6:0];
        c.kind = CMD_UNKNOWN;
        if (b[7])
            c.kind = CMD_LEVEL;
        else if (b[7:5] == 3'b010)
            c.kind = CMD_DIR;
        else if (b == 8'h00)
            c.kind = CMD_BANNER;
        else if (b == 8'h01)
            c.kind = CMD_SPI;
        else if (b == 8'h0F)
            c.kind = CMD_RESET;
        return c;
    endfunction

endpackage

// File: rtl/bbio_entry_det.sv
module bbio_entry_det #(
    parameter int ENTRY_ZEROS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic byte_valid,
    input  logic byte_zero,
    output logic hit
);
    localparam int CW = $clog2(ENTRY_ZEROS + 1);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_ZEROS - 1);

    logic [CW-1:0] zero_cnt;

    assign hit = byte_valid && byte_zero && (zero_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            zero_cnt <= '0;
        else if (byte_valid) begin
            if (!byte_zero || hit)
                zero_cnt <= '0;
            else
                zero_cnt <= zero_cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        zero_cnt <= LAST); // R2

    AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_zero) |=> zero_cnt == '0); // R3

endmodule

// File: rtl/bbio_pin_bank.sv
module bbio_pin_bank #(
    parameter int NPINS = 7,
    parameter int NDIR  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             float_all,
    input  logic             dir_we,
    input  logic [NDIR-1:0]  dir_val,
    input  logic             lvl_we,
    input  logic [NPINS-1:0] lvl_val,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic lvl_q;
        always_ff @(posedge clk) begin
            if (rst || float_all)
                lvl_q <= 1'b0;
            else if (lvl_we)
                lvl_q <= lvl_val[i];
        end
        assign pin_out[i] = lvl_q;

        if (i < NDIR) begin : g_dir
            logic is_input_q;
            always_ff @(posedge clk) begin
                if (rst || float_all)
                    is_input_q <= 1'b1;
                else if (dir_we)
                    is_input_q <= dir_val[i];
            end
            assign pin_oe[i] = !is_input_q;
        end else begin : g_fixed
            assign pin_oe[i] = 1'b1;
        end
    end

    logic past_valid;
    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    AST_FLOAT_APPLIED: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(float_all)) |-> (pin_oe[NDIR-1:0] == '0 && pin_out == '0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(float_all) && !$past(dir_we) && !$past(lvl_we))
            |-> ($stable(pin_oe) && $stable(pin_out))); // R10

endmodule

// File: rtl/bbio_reply.sv
module bbio_reply
    import bbio_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PIN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_banner,
    input  logic             start_pin,
    input  logic             start_byte,
    input  logic [DW-1:0]    byte_val,
    input  logic [PIN_W-1:0] pin_in,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [DW-1:0]    tx_data,
    output logic             busy
);
    localparam logic [2:0] LAST_IDX = 3'(BANNER_LEN - 1);

    reply_e         state;
    logic [2:0]     idx;
    logic [DW-1:0]  data_q;

    assign busy     = (state != RP_IDLE);
    assign tx_valid = (state == RP_BANNER) || (state == RP_BYTE);
    assign tx_data  = (state == RP_BANNER) ? banner_char(idx) : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RP_IDLE;
            idx    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                RP_IDLE: begin
                    if (start_banner) begin
                        state <= RP_BANNER;
                        idx   <= '0;
                    end else if (start_pin)
                        state <= RP_CAPTURE;
                    else if (start_byte) begin
                        state  <= RP_BYTE;
                        data_q <= byte_val;
                    end
                end
                RP_CAPTURE: begin
                    data_q <= {{(DW-PIN_W){1'b0}}, pin_in};
                    state  <= RP_BYTE;
                end
                RP_BANNER: begin
                    if (tx_ready) begin
                        if (idx == LAST_IDX)
                            state <= RP_IDLE;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (tx_ready)
                        state <= RP_IDLE;
                end
            endcase
        end
    end

    AST_BANNER_IDX: assert property (@(posedge clk) disable iff (rst)
        (state == RP_BANNER) |-> (idx <= LAST_IDX)); // R2

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (start_banner || start_pin || start_byte) |-> (state == RP_IDLE)); // R11

    AST_CAPTURE_THEN_SEND: assert property (@(posedge clk) disable iff (rst)
        (state == RP_CAPTURE) |=> (state == RP_BYTE)); // R8

endmodule

// File: rtl/bbio_ctrl.sv
module bbio_ctrl
    import bbio_pkg::*;
#(
    parameter int ENTRY_ZEROS = 20,
    parameter int NPINS       = 7,
    parameter int NDIR        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             term_valid,
    output logic [7:0]       term_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic             spi_active,
    output logic             spi_rx_valid,
    output logic [7:0]       spi_rx_data,
    input  logic             spi_exit,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    mode_e mode;
    cmd_t  cmd;
    logic  busy, accept, in_term, raw_acc, entry_hit, spi_ret;
    logic  start_banner, start_pin, start_byte, float_all;

    assign rx_ready   = !busy;
    assign accept     = rx_valid && rx_ready;
    assign in_term    = (mode == MODE_TERM);
    assign spi_active = (mode == MODE_SPI);
    assign cmd        = decode_cmd(rx_data);
    assign raw_acc    = accept && (mode == MODE_RAW);
    assign spi_ret    = spi_active && spi_exit;

    assign term_valid   = accept && in_term && (rx_data != 8'h00);
    assign term_data    = rx_data;
    assign spi_rx_valid = accept && spi_active;
    assign spi_rx_data  = rx_data;

    bbio_entry_det #(.ENTRY_ZEROS(ENTRY_ZEROS)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .clear      (!in_term),
        .byte_valid (accept && in_term),
        .byte_zero  (rx_data == 8'h00),
        .hit        (entry_hit)
    );

    assign start_banner = entry_hit || spi_ret || (raw_acc && cmd.kind == CMD_BANNER);
    assign start_pin    = raw_acc && (cmd.kind == CMD_DIR || cmd.kind == CMD_LEVEL);
    assign start_byte   = raw_acc && (cmd.kind == CMD_UNKNOWN);
    assign float_all    = entry_hit || spi_ret || (raw_acc && cmd.kind == CMD_RESET);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_TERM;
        else if (entry_hit || spi_ret)
            mode <= MODE_RAW;
        else if (raw_acc && cmd.kind == CMD_SPI)
            mode <= MODE_SPI;
        else if (raw_acc && cmd.kind == CMD_RESET)
            mode <= MODE_TERM;
    end

    bbio_pin_bank #(.NPINS(NPINS), .NDIR(NDIR)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .float_all (float_all),
        .dir_we    (raw_acc && cmd.kind == CMD_DIR),
        .dir_val   (cmd.arg[NDIR-1:0]),
        .lvl_we    (raw_acc && cmd.kind == CMD_LEVEL),
        .lvl_val   (cmd.arg[NPINS-1:0]),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    bbio_reply #(.DW(8), .PIN_W(NPINS)) u_reply (
        .clk          (clk),
        .rst          (rst),
        .start_banner (start_banner),
        .start_pin    (start_pin),
        .start_byte   (start_byte),
        .byte_val     (8'h00),
        .pin_in       (pin_in),
        .tx_ready     (tx_ready),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .busy         (busy)
    );

    logic past_valid;
    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    AST_TERM_SILENT: assert property (@(posedge clk) disable iff (rst)
        in_term |-> !tx_valid); // R2

    AST_TERM_NONZERO: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> (!spi_rx_valid && !tx_valid)); // R3

    AST_SPI_SILENT: assert property (@(posedge clk) disable iff (rst)
        spi_active |-> (!tx_valid && !term_valid)); // R5

    AST_RESET_TO_TERM: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(raw_acc && cmd.kind == CMD_RESET)) |-> (in_term && !tx_valid)); // R7

    AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(start_byte))
            |-> ($stable(pin_out) && $stable(pin_oe) && mode == MODE_RAW)); // R10

    AST_READY_WHILE_TX: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready); // R11

endmodule

// File: tb/tb_bbio_ctrl.sv
module tb_bbio_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready, term_valid, tx_valid, spi_active, spi_rx_valid;
    logic [7:0] term_data, tx_data, spi_rx_data;
    logic       tx_ready = 1'b1;
    logic       spi_exit = 1'b0;
    logic [6:0] pin_in, pin_out, pin_oe;
    logic [6:0] ext = 7'h00;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] txq[$];
    logic       saw_term, saw_spi;
    logic [7:0] got_term, got_spi;

    // model of the pin settings
    logic [4:0] m_dir = 5'h1F;
    logic [6:0] m_lvl = 7'h00;

    always #5 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    bbio_ctrl dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .term_valid(term_valid), .term_data(term_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .spi_active(spi_active), .spi_rx_valid(spi_rx_valid),
        .spi_rx_data(spi_rx_data), .spi_exit(spi_exit), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) txq.push_back(tx_data);
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            report();
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] d, input logic [6:0] l,
                                            input logic [6:0] e);
        logic [6:0] oe;
        oe = {2'b11, ~d};
        return {1'b0, (oe & l) | (~oe & e)};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        saw_term = term_valid; got_term = term_data;
        saw_spi  = spi_rx_valid; got_spi = spi_rx_data;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (10) @(negedge clk);
    endtask

    task automatic expect_banner(input string tag);
        logic [7:0] exp [5];
        exp = '{8'h42, 8'h42, 8'h49, 8'h4F, 8'h31};
        chk(txq.size(), 5, tag);
        for (int i = 0; i < 5; i++)
            if (txq.size() > 0) chk(txq.pop_front(), exp[i], tag);
        txq.delete();
    endtask

    task automatic expect_one(input logic [7:0] v, input string tag);
        chk(txq.size(), 1, tag);
        if (txq.size() > 0) chk(txq.pop_front(), v, tag);
        txq.delete();
    endtask

    task automatic expect_none(input string tag);
        chk(txq.size(), 0, tag);
        txq.delete();
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_byte(8'h00);
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(spi_active, 0, "R1 spi_active");
        chk(tx_valid, 0, "R1 tx_valid");
        chk(pin_oe, 7'b1100000, "R1 pin_oe");
        chk(pin_out, 7'h00, "R1 pin_out");

        // R3 zeros are held back, non-zero byte is forwarded and clears the run
        send_byte(8'h00);
        chk(saw_term, 0, "R3 zero not forwarded");
        send_zeros(18);
        send_byte(8'h41);
        chk(saw_term, 1, "R3 term_valid");
        chk(got_term, 8'h41, "R3 term_data");
        drain();
        expect_none("R2 nineteen zeros no reply");
        send_zeros(19);
        drain();
        expect_none("R3 count cleared by non-zero byte");

        // R2 twentieth zero enters, R11 back-pressure during banner
        send_byte(8'h00);
        chk(rx_ready, 0, "R11 rx_ready low during banner");
        drain();
        expect_banner("R2 entry banner");
        chk(rx_ready, 1, "R11 rx_ready after banner");

        // R4 banner repeat
        send_byte(8'h00);
        drain();
        expect_banner("R4 banner repeat");

        // R8 R9 R10 random pin and undefined commands
        for (int it = 0; it < 60; it++) begin
            int sel;
            logic [6:0] oe_b, out_b;
            ext = 7'($urandom);
            sel = $urandom_range(0, 2);
            b = 8'($urandom);
            oe_b = pin_oe; out_b = pin_out;
            if (sel == 0) begin
                b[7:5] = 3'b010;
                m_dir = b[4:0];
                send_byte(b); drain();
                expect_one(exp_read(m_dir, m_lvl, ext), "R8 direction reply");
                chk(pin_oe, {2'b11, ~m_dir}, "R8 pin_oe");
            end else if (sel == 1) begin
                b[7] = 1'b1;
                m_lvl = b[6:0];
                send_byte(b); drain();
                expect_one(exp_read(m_dir, m_lvl, ext), "R9 level reply");
                chk(pin_out, m_lvl, "R9 pin_out");
            end else begin
                b[7] = 1'b0;
                if (b[7:5] == 3'b010) b[5] = 1'b1;
                if (b == 8'h00 || b == 8'h01 || b == 8'h0F) b = 8'h0E;
                send_byte(b); drain();
                expect_one(8'h00, "R10 unknown reply");
                chk({pin_oe, pin_out}, {oe_b, out_b}, "R10 pins unchanged");
                chk(spi_active, 0, "R10 mode unchanged");
            end
        end

        // R10 directed low codes
        send_byte(8'h02); drain();
        expect_one(8'h00, "R10 code 0x02");

        // R5 SPI handoff with pins driven first
        send_byte(8'h5F & 8'h40); drain(); txq.delete(); m_dir = 5'h00;
        send_byte(8'hFF); drain(); txq.delete(); m_lvl = 7'h7F;
        send_byte(8'h01); drain();
        chk(spi_active, 1, "R5 spi_active");
        expect_none("R5 no reply on handoff");
        send_byte(8'hAB);
        chk(saw_spi, 1, "R5 spi_rx_valid");
        chk(got_spi, 8'hAB, "R5 spi_rx_data");
        chk(saw_term, 0, "R5 not on terminal path");
        drain();
        expect_none("R5 silent in SPI");

        // R6 return from SPI
        @(negedge clk); spi_exit = 1'b1;
        @(negedge clk); spi_exit = 1'b0;
        chk(spi_active, 0, "R6 spi_active cleared");
        chk(pin_oe, 7'b1100000, "R6 pins floated");
        chk(pin_out, 7'h00, "R6 levels cleared");
        drain();
        expect_banner("R6 return banner");

        // R7 reset to terminal and re-entry
        send_byte(8'hC3); drain(); txq.delete();
        send_byte(8'h0F); drain();
        expect_none("R7 no reply");
        chk(pin_out, 7'h00, "R7 levels cleared");
        chk(pin_oe, 7'b1100000, "R7 pins floated");
        send_byte(8'h33);
        chk(saw_term, 1, "R7 terminal mode forwards");
        send_zeros(19); drain();
        expect_none("R7 nineteen zeros after reset");
        send_byte(8'h00); drain();
        expect_banner("R7 re-entry banner");

        report();
    end
endmodule